// File: doc/BRIEF.md
# Accumulator Stored-Program Processor (Multicycle)

This block is a small processor for teaching. It keeps its program and its data in one shared word memory. Each instruction goes through a fixed series of register-transfer steps, and each step can be seen from outside. The program counter is copied to the address register. The addressed word is captured in the data register while the counter advances. The word then moves into the instruction register, is split into opcode and address, and is executed. Every memory access, for an instruction or for an operand, uses the address register and the data register, so the memory has one port and no other path to it.

A host loads the memory through a simple write port while it holds the core in reset. It then releases reset and pulses `start`. Debug outputs show the value of every architectural register and the current step on every cycle. A HALT instruction freezes the core until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: With `rst_n` low at a clock edge, PC, MAR, MDR, CIR and ACC all become zero, `dbg_step` becomes 0 (idle) and `halted` becomes low. The core stays idle until `start` is seen high at an edge.
- R2: While `rst_n` is low, each edge with `ld_we` high writes `ld_data` into memory at `ld_addr`. The words loaded this way are the ones the core later fetches and uses as data.
- R3: The step code on `dbg_step` follows this order: 1 (MAR takes PC), 2 (MDR takes the addressed word and PC increments by one), 3 (CIR takes MDR), then 4, 5, 6 for execute. Step 7 means halted.
- R4: An instruction word is 16 bits. Bits [15:12] are the opcode and bits [11:0] are a direct word address. The opcodes are 0 HALT, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 JMP, 6 JZ and 7 NOP.
- R5: LOAD places the addressed word in ACC. ADD and SUB combine ACC with the addressed word, modulo 2^16. Each of these takes 6 cycles, and ACC changes only in step 6.
- R6: STORE copies ACC through MDR into the addressed word and takes 5 cycles. A stored word can later be fetched and run as an instruction.
- R7: JMP replaces PC with the address field and takes 4 cycles.
- R8: JZ replaces PC with the address field only when ACC is zero. Otherwise PC keeps its advanced value. Both cases take 4 cycles.
- R9: HALT takes 4 cycles and then raises `halted`. After that no register changes and `start` has no effect until reset.
- R10: NOP and the opcodes 8 to 15 change nothing except PC, MAR, MDR and CIR through the fetch, and each takes 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also enables the load port |
| ld_we | input | 1 | Load-port write strobe (used only in reset) |
| ld_addr | input | 12 | Load-port word address |
| ld_data | input | 16 | Load-port write data |
| start | input | 1 | Begins execution at address 0 from idle |
| halted | output | 1 | High once HALT has executed |
| dbg_pc | output | 12 | Program counter |
| dbg_mar | output | 12 | Memory address register |
| dbg_mdr | output | 16 | Memory data register |
| dbg_cir | output | 16 | Current instruction register |
| dbg_acc | output | 16 | Accumulator |
| dbg_step | output | 3 | Current step code |

## Verification
The hardest case to reach is a program that rewrites one of its own instructions before fetching it. From the ports, the only way to make this happen is to load a program whose STORE targets a later instruction address. A directed program therefore stores an ADD word over a HALT slot and then runs into that slot. The expected accumulator differs depending on whether the fetch returned the new word or the old one. Random straight-line programs with forward-only jumps and wrapping arithmetic are compared with a bench instruction model, which checks the final registers and the exact cycle count.

// File: rtl/cpu_pkg.sv
// Shared definitions for the accumulator processor: step codes,
// opcode values, ALU operations and the control word the sequencer
// produces each cycle. Assumes a 4-bit opcode field at the top of
// each instruction word.
package cpu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH1 = 3'd1,
        ST_FETCH2 = 3'd2,
        ST_DECODE = 3'd3,
        ST_EXEC1  = 3'd4,
        ST_EXEC2  = 3'd5,
        ST_EXEC3  = 3'd6,
        ST_HALTED = 3'd7
    } step_e;

    localparam int OPC_HALT  = 0;
    localparam int OPC_LOAD  = 1;
    localparam int OPC_STORE = 2;
    localparam int OPC_ADD   = 3;
    localparam int OPC_SUB   = 4;
    localparam int OPC_JMP   = 5;
    localparam int OPC_JZ    = 6;

    typedef enum logic [2:0] {
        OC_HALT, OC_LOAD, OC_STORE, OC_ADD, OC_SUB, OC_JMP, OC_JZ, OC_NOP
    } op_class_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    mar_from_pc;
        logic    mar_from_opnd;
        logic    mdr_from_mem;
        logic    mdr_from_acc;
        logic    pc_inc;
        logic    pc_jump;
        logic    cir_load;
        logic    acc_load;
        logic    mem_we;
        alu_op_e alu_op;
    } ctl_t;

endpackage

// File: rtl/cpu_mem.sv
// Single-port word memory shared by instructions and data.
// Reads are combinational from the one address and writes are
// synchronous. The caller muxes between the load port and the core.
module cpu_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Write the addressed word when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= wdata;
        end
    end

    // Present the addressed word.
    assign rdata = words[addr];
endmodule

// File: rtl/cpu_alu.sv
// Accumulator ALU: passes the memory operand through, or adds it to /
// subtracts it from the accumulator, wrapping modulo 2^W.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] result
);
    // Select the operation result.
    always_comb begin
        unique case (op)
            ALU_ADD: result = acc + opnd;
            ALU_SUB: result = acc - opnd;
            default: result = opnd;
        endcase
    end
endmodule

// File: rtl/cpu_ctrl.sv
// Sequencer for the multicycle core. It steps through fetch, decode
// and execute, and drives one control word per cycle. It assumes the
// opcode comes from the instruction register, so it is valid from the
// first execute step on.
module cpu_ctrl
    import cpu_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] opcode,
    input  logic            acc_zero,
    output step_e           state,
    output ctl_t            ctl
);
    step_e     nxt;
    op_class_e cls;

    // Map the raw opcode to an operation class; unknown codes act as NOP.
    always_comb begin
        if      (opcode == OP_W'(OPC_HALT))  cls = OC_HALT;
        else if (opcode == OP_W'(OPC_LOAD))  cls = OC_LOAD;
        else if (opcode == OP_W'(OPC_STORE)) cls = OC_STORE;
        else if (opcode == OP_W'(OPC_ADD))   cls = OC_ADD;
        else if (opcode == OP_W'(OPC_SUB))   cls = OC_SUB;
        else if (opcode == OP_W'(OPC_JMP))   cls = OC_JMP;
        else if (opcode == OP_W'(OPC_JZ))    cls = OC_JZ;
        else                                 cls = OC_NOP;
    end

    // Compute the next step and this cycle's control word.
    always_comb begin
        ctl = '0;
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_FETCH1;
            end
            ST_FETCH1: begin
                ctl.mar_from_pc = 1'b1;
                nxt = ST_FETCH2;
            end
            ST_FETCH2: begin
                ctl.mdr_from_mem = 1'b1;
                ctl.pc_inc       = 1'b1;
                nxt = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.cir_load = 1'b1;
                nxt = ST_EXEC1;
            end
            ST_EXEC1: begin
                unique case (cls)
                    OC_HALT: nxt = ST_HALTED;
                    OC_JMP: begin
                        ctl.pc_jump = 1'b1;
                        nxt = ST_FETCH1;
                    end
                    OC_JZ: begin
                        ctl.pc_jump = acc_zero;
                        nxt = ST_FETCH1;
                    end
                    OC_LOAD, OC_ADD, OC_SUB: begin
                        ctl.mar_from_opnd = 1'b1;
                        nxt = ST_EXEC2;
                    end
                    OC_STORE: begin
                        ctl.mar_from_opnd = 1'b1;
                        ctl.mdr_from_acc  = 1'b1;
                        nxt = ST_EXEC2;
                    end
                    default: nxt = ST_FETCH1;
                endcase
            end
            ST_EXEC2: begin
                if (cls == OC_STORE) begin
                    ctl.mem_we = 1'b1;
                    nxt = ST_FETCH1;
                end else begin
                    ctl.mdr_from_mem = 1'b1;
                    nxt = ST_EXEC3;
                end
            end
            ST_EXEC3: begin
                ctl.acc_load = 1'b1;
                if      (cls == OC_ADD) ctl.alu_op = ALU_ADD;
                else if (cls == OC_SUB) ctl.alu_op = ALU_SUB;
                else                    ctl.alu_op = ALU_PASS;
                nxt = ST_FETCH1;
            end
            default: nxt = ST_HALTED;
        endcase
    end

    // Hold the current step; reset returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/acc_cpu.sv
// Top of the accumulator processor. It holds the architectural
// registers (PC, MAR, MDR, CIR, ACC), the shared memory, the ALU and
// the sequencer. Memory is reached only through MAR/MDR while running.
// While reset is held, the load port owns the memory port.
module acc_cpu
    import cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              start,
    output logic              halted,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [ADDR_W-1:0] dbg_mar,
    output logic [DATA_W-1:0] dbg_mdr,
    output logic [DATA_W-1:0] dbg_cir,
    output logic [DATA_W-1:0] dbg_acc,
    output logic [2:0]        dbg_step
);
    localparam int OP_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc, mar;
    logic [DATA_W-1:0] mdr, cir, acc;
    logic [DATA_W-1:0] mem_rdata, alu_y;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we;
    step_e             state;
    ctl_t              ctl;

    // Give the memory port to the loader during reset, else to MAR/MDR.
    always_comb begin
        if (!rst_n) begin
            mem_addr  = ld_addr;
            mem_wdata = ld_data;
            mem_we    = ld_we;
        end else begin
            mem_addr  = mar;
            mem_wdata = mdr;
            mem_we    = ctl.mem_we;
        end
    end

    cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    cpu_alu #(.W(DATA_W)) u_alu (
        .op     (ctl.alu_op),
        .acc    (acc),
        .opnd   (mdr),
        .result (alu_y)
    );

    cpu_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .opcode   (cir[DATA_W-1:ADDR_W]),
        .acc_zero (acc == '0),
        .state    (state),
        .ctl      (ctl)
    );

    // Register transfers selected by the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            mdr <= '0;
            cir <= '0;
            acc <= '0;
        end else begin
            if (ctl.mar_from_pc)        mar <= pc;
            else if (ctl.mar_from_opnd) mar <= cir[ADDR_W-1:0];
            if (ctl.mdr_from_mem)       mdr <= mem_rdata;
            else if (ctl.mdr_from_acc)  mdr <= acc;
            if (ctl.pc_jump)            pc  <= cir[ADDR_W-1:0];
            else if (ctl.pc_inc)        pc  <= pc + 1'b1;
            if (ctl.cir_load)           cir <= mdr;
            if (ctl.acc_load)           acc <= alu_y;
        end
    end

    assign halted   = (state == ST_HALTED);
    assign dbg_pc   = pc;
    assign dbg_mar  = mar;
    assign dbg_mdr  = mdr;
    assign dbg_cir  = cir;
    assign dbg_acc  = acc;
    assign dbg_step = state;
endmodule

// File: rtl/acc_cpu_chk.sv
// Temporal checks on the processor's debug ports, bound to acc_cpu.
// Assumes the step codes listed in the brief.
module acc_cpu_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              halted,
    input logic [ADDR_W-1:0] dbg_pc,
    input logic [ADDR_W-1:0] dbg_mar,
    input logic [DATA_W-1:0] dbg_mdr,
    input logic [DATA_W-1:0] dbg_cir,
    input logic [DATA_W-1:0] dbg_acc,
    input logic [2:0]        dbg_step
);
    localparam int OP_W = DATA_W - ADDR_W;

    logic [OP_W-1:0] op;
    assign op = dbg_cir[DATA_W-1:ADDR_W];

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (dbg_pc == '0 && dbg_acc == '0 && dbg_cir == '0 && dbg_step == 3'd0 && !halted)); // R1
    AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (dbg_step == 3'd0 && !start) |=> dbg_step == 3'd0); // R1
    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n) dbg_step == 3'd1 |=> (dbg_step == 3'd2 && dbg_mar == $past(dbg_pc))); // R3
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) dbg_step == 3'd2 |=> (dbg_step == 3'd3 && dbg_pc == $past(dbg_pc) + 1'b1)); // R3
    AST_CIR_COPY: assert property (@(posedge clk) disable iff (!rst_n) dbg_step == 3'd3 |=> dbg_cir == $past(dbg_mdr)); // R3
    AST_ACC_STEP6: assert property (@(posedge clk) disable iff (!rst_n) dbg_step != 3'd6 |=> $stable(dbg_acc)); // R5
    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (dbg_step == 3'd4 && op == OP_W'(5)) |=> dbg_pc == $past(dbg_cir[ADDR_W-1:0])); // R7
    AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (dbg_step == 3'd4 && op == OP_W'(6) && dbg_acc == '0) |=> dbg_pc == $past(dbg_cir[ADDR_W-1:0])); // R8
    AST_JZ_SKIP: assert property (@(posedge clk) disable iff (!rst_n) (dbg_step == 3'd4 && op == OP_W'(6) && dbg_acc != '0) |=> $stable(dbg_pc)); // R8
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (dbg_step == 3'd4 && op == OP_W'(0)) |=> halted); // R9
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) halted |=> (halted && $stable(dbg_pc) && $stable(dbg_acc) && $stable(dbg_mdr))); // R9
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_acc_cpu.sv
// Bench for acc_cpu: directed and seeded-random programs compared
// with an instruction-level model kept in the bench.
module test_acc_cpu;
    localparam int DW = 16;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          start = 1'b0;
    logic          halted;
    logic [AW-1:0] dbg_pc, dbg_mar;
    logic [DW-1:0] dbg_mdr, dbg_cir, dbg_acc;
    logic [2:0]    dbg_step;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] img  [0:4095];
    logic [DW-1:0] work [0:4095];

    acc_cpu i_acc_cpu (.*);

    always #2 clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ins(int op, int a);
        return {op[3:0], a[11:0]};
    endfunction

    // Blank program area (all HALT) and data area.
    task automatic clear_img();
        for (int a = 0; a < 64; a++) img[a] = '0;
        for (int a = 256; a < 272; a++) img[a] = '0;
    endtask

    // Hold reset, write image through the load port, release.
    task automatic load_img();
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < 272; a++) begin
            if (a < 64 || a >= 256) begin
                @(negedge clk);
                ld_we = 1'b1; ld_addr = AW'(a); ld_data = img[a];
            end
        end
        @(negedge clk);
        ld_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Instruction model: final registers and cycle count.
    task automatic model(output logic [DW-1:0] acc, output logic [AW-1:0] pc,
                         output logic [AW-1:0] mar, output logic [DW-1:0] mdr,
                         output logic [DW-1:0] cir, output int cyc);
        logic [DW-1:0] w;
        logic [AW-1:0] a;
        bit done;
        for (int i = 0; i < 4096; i++) work[i] = img[i];
        acc = '0; pc = '0; cyc = 0; done = 0;
        mar = '0; mdr = '0; cir = '0;
        for (int n = 0; n < 2000 && !done; n++) begin
            w = work[pc]; mar = pc; mdr = w; cir = w; pc = pc + 1'b1;
            a = w[AW-1:0];
            case (w[15:12])
                4'd0: begin cyc += 4; done = 1; end
                4'd1: begin mar = a; mdr = work[a]; acc = mdr; cyc += 6; end
                4'd2: begin mar = a; mdr = acc; work[a] = acc; cyc += 5; end
                4'd3: begin mar = a; mdr = work[a]; acc = acc + mdr; cyc += 6; end
                4'd4: begin mar = a; mdr = work[a]; acc = acc - mdr; cyc += 6; end
                4'd5: begin pc = a; cyc += 4; end
                4'd6: begin if (acc == '0) pc = a; cyc += 4; end
                default: cyc += 4;
            endcase
        end
    endtask

    // Load, check reset state, run to halt and compare with the model.
    task automatic run_prog(string tag);
        logic [DW-1:0] e_acc, e_mdr, e_cir;
        logic [AW-1:0] e_pc, e_mar;
        int e_cyc, cnt;
        for (int i = 0; i < 4096; i++) if (!((i < 64) || (i >= 256 && i < 272))) img[i] = '0;
        model(e_acc, e_pc, e_mar, e_mdr, e_cir, e_cyc);
        load_img();
        chk("R1", "reset pc", dbg_pc, 0);
        chk("R1", "reset acc+step", {dbg_acc, 13'd0, dbg_step}, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!halted && cnt < 3000) begin
            @(negedge clk);
            cnt++;
        end
        chk(tag, "cycles to halt", cnt, e_cyc);
        chk(tag, "acc", dbg_acc, e_acc);
        chk(tag, "pc", dbg_pc, e_pc);
        chk(tag, "mar", dbg_mar, e_mar);
        chk(tag, "mdr/cir", {dbg_mdr, dbg_cir}, {e_mdr, e_cir});
        chk("R9", "halted flag", {29'd0, dbg_step}, 7);
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R9 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] hp;
        logic [DW-1:0] ha;
        int exp_step, idx;
        void'($urandom(32'd20240611));

        // R1: idle without start
        clear_img();
        load_img();
        repeat (4) @(negedge clk);
        chk("R1", "idle without start", {dbg_step, dbg_pc}, 0);
        chk("R1", "not halted", halted, 0);

        // R3: exact step trace, MAR at step 2 = instruction address
        clear_img();
        img[0] = ins(1, 256); img[1] = ins(3, 257); img[2] = ins(2, 258);
        img[3] = ins(7, 0);   img[4] = ins(0, 0);
        img[256] = 16'd5; img[257] = 16'd9;
        load_img();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 0;
        foreach (img[i]) if (i < 5) begin
            int n;
            n = (i < 2) ? 6 : (i == 2) ? 5 : 4;
            for (int k = 1; k <= n; k++) begin
                chk("R3", "step code", dbg_step, k);
                if (k == 2) chk("R3", "mar holds fetch address", dbg_mar, i);
                @(negedge clk);
                idx++;
            end
        end
        chk("R3", "final step halted", dbg_step, 7);
        chk("R5", "acc after load+add", dbg_acc, 14);

        // R2/R5: arithmetic wrap
        clear_img();
        img[0] = ins(4, 256); img[1] = ins(3, 257); img[2] = ins(3, 257);
        img[256] = 16'd1; img[257] = 16'h8000;
        run_prog("R5");

        // R7/R8: JZ taken, JMP, JZ not taken
        clear_img();
        img[0] = ins(6, 5); img[5] = ins(1, 256); img[6] = ins(6, 9);
        img[7] = ins(5, 12); img[12] = ins(3, 256); img[13] = ins(0, 0);
        img[256] = 16'h0042;
        run_prog("R8");
        clear_img();
        img[0] = ins(5, 40); img[40] = ins(1, 257); img[41] = ins(5, 44);
        img[42] = ins(3, 257); img[44] = ins(0, 0); img[257] = 16'h1234;
        run_prog("R7");

        // R6: self-modifying code overwrites the HALT at 3 with ADD 257
        clear_img();
        img[0] = ins(1, 256); img[1] = ins(2, 3); img[2] = ins(1, 258);
        img[3] = ins(0, 0);   img[4] = ins(0, 0);
        img[256] = ins(3, 257); img[257] = 16'd100; img[258] = 16'd23;
        run_prog("R6");
        chk("R6", "acc from rewritten instruction", dbg_acc, 123);

        // R10: undefined opcodes and NOP leave ACC alone
        clear_img();
        img[0] = ins(1, 256); img[1] = ins(9, 256); img[2] = ins(15, 4095);
        img[3] = ins(7, 1); img[4] = ins(12, 0); img[256] = 16'h00AA;
        run_prog("R10");

        // R9: start after halt has no effect
        hp = dbg_pc; ha = dbg_acc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9", "pc frozen after halt", dbg_pc, hp);
        chk("R9", "acc frozen after halt", dbg_acc, ha);
        chk("R9", "still halted", halted, 1);

        // R4/R2: seeded random forward-only programs
        for (int t = 0; t < 30; t++) begin
            int len;
            clear_img();
            len = $urandom_range(8, 40);
            for (int a = 256; a < 272; a++) begin
                case ($urandom_range(0, 3))
                    0: img[a] = '0;
                    1: img[a] = 16'hFFFF;
                    default: img[a] = DW'($urandom);
                endcase
            end
            for (int i = 0; i < len; i++) begin
                int d, tg;
                d  = 256 + $urandom_range(0, 15);
                tg = i + 1 + $urandom_range(0, 4);
                if (tg > 63) tg = 63;
                case ($urandom_range(0, 9))
                    0, 1: img[i] = ins(1, d);
                    2, 9: img[i] = ins(3, d);
                    3: img[i] = ins(4, d);
                    4: img[i] = ins(2, d);
                    5: img[i] = ins(6, tg);
                    6: img[i] = ins(5, tg);
                    7: img[i] = ins(7, d);
                    default: img[i] = ins($urandom_range(8, 15), d);
                endcase
            end
            run_prog("R4");
        end

        exp_step = idx;
        if (exp_step < 0) $display("FAIL R3 trace index: actual %0d expected >=0", exp_step);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule